// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Comparator

This block watches every bus cycle a processor issues and raises a break request when a cycle meets the conditions programmed on channel A or channel B. Each channel compares the cycle address with a reference address. Any reference bit whose mask bit is 1 is left out of the compare. The match is then qualified by the bus the cycle ran on, by whether it is an instruction fetch or a data access, and by its direction. Operand size can be part of the condition or can be ignored. Channel B can also require that the bus data agrees with a reference value under a data mask.

The two channels run either independently or in sequence. In sequence mode a channel A match only arms the unit, and a later channel B match raises the break. For an instruction fetch, the break can be taken before the instruction executes, which is the same cycle as the fetch. It can also be taken after execution, on the cycle where the core reports that the instruction has completed. A per-channel hit flag records each match until software clears it.

The bus side only observes cycles. It has no ready signal, so the block never applies back-pressure and must judge every cycle that has `bus_valid` set. Configuration is written through a simple single-cycle write strobe.

Top module: `bkpt_unit`

## Requirements
- R1: A channel matches only when every address bit whose mask bit is 0 equals the reference. With reference 0x00008010 and mask 0x00000006, fetches at 0x8010, 0x8012, 0x8014 and 0x8016 match, and 0x8011 and 0x8018 do not.
- R2: The condition word (register 2 for A, register 5 for B) qualifies the match. Bits [1:0] select the bus: bit 0 is the local bus (`bus_sel`=0) and bit 1 is the peripheral bus. Bits [3:2] select the kind: bit 2 is fetch and bit 3 is data. Bits [5:4] select the direction: bit 4 is read and bit 5 is write. A cycle matches only if the bit for its own bus, kind and direction is set.
- R3: Condition bits [7:6] give the size. A value of 0 ignores `bus_size`. Any other value (1 byte, 2 word, 3 long) must equal `bus_size`.
- R4: A channel whose bus, kind or direction field is 0 never matches.
- R5: Channel B also needs (`bus_data` XOR data register 6) AND NOT data mask register 7 to be zero. A mask bit of 1 excludes that data bit.
- R6: In independent mode (control register 8, bit 0 = 0), a match on either channel raises `brk_req`.
- R7: In sequence mode (bit 0 = 1), a channel A match sets an armed state and raises no break. A channel B match while armed raises the break and clears the armed state. A channel B match while not armed raises nothing.
- R8: Any write to control register 8 clears the armed state.
- R9: A match on a data cycle, or on a fetch whose condition bit 8 is 0, drives `brk_req` in the same cycle as the matching bus cycle.
- R10: A fetch match with condition bit 8 = 1 raises no break at the fetch. It is held pending, and `brk_req` is asserted on the next cycle with `insn_done` high. The pending state clears in that cycle.
- R11: `hit_flag_a` and `hit_flag_b` are set on the clock edge after their channel matches, in either mode. Writing register 9 with bit 0 (A) or bit 1 (B) equal to 0 clears that flag. A match in the same cycle wins over the clear.
- R12: After reset all registers are 0, the unit is in independent mode, and `brk_req` and both hit flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Register index 0..9 |
| cfg_wdata | input | 32 | Write data |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_sel | input | 1 | 0 local bus, 1 peripheral bus |
| bus_ifetch | input | 1 | 1 instruction fetch, 0 data access |
| bus_write | input | 1 | 1 write, 0 read |
| bus_size | input | 2 | 1 byte, 2 word, 3 long |
| bus_addr | input | 32 | Cycle address |
| bus_data | input | 32 | Cycle data |
| insn_done | input | 1 | A previously fetched instruction completes this clock |
| brk_req | output | 1 | Break request |
| hit_flag_a | output | 1 | Channel A match flag |
| hit_flag_b | output | 1 | Channel B match flag |

## Verification
Directed patterns come first. Addresses around the masked window separate masked bits from compared bits. Cycles that differ from the condition in only one field (bus, kind, direction or size) show that each qualifier is decoded on its own. Data values that differ only inside or only outside the data mask test the channel B data path. A fetch, then idle cycles, then a completion strobe separates the pre-execution timing from the post-execution timing. A B-only, then A, then B order tells armed from unarmed sequencing. After these, random configurations and random cycles drawn near the programmed addresses mix both modes, status clears and completion strobes, and are compared against a cycle model in the bench.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int unsigned REG_IDX_W = 4;

  localparam logic [REG_IDX_W-1:0] IDX_A_ADDR  = 4'd0;
  localparam logic [REG_IDX_W-1:0] IDX_A_MASK  = 4'd1;
  localparam logic [REG_IDX_W-1:0] IDX_A_COND  = 4'd2;
  localparam logic [REG_IDX_W-1:0] IDX_B_ADDR  = 4'd3;
  localparam logic [REG_IDX_W-1:0] IDX_B_MASK  = 4'd4;
  localparam logic [REG_IDX_W-1:0] IDX_B_COND  = 4'd5;
  localparam logic [REG_IDX_W-1:0] IDX_B_DATA  = 4'd6;
  localparam logic [REG_IDX_W-1:0] IDX_B_DMASK = 4'd7;
  localparam logic [REG_IDX_W-1:0] IDX_CTRL    = 4'd8;
  localparam logic [REG_IDX_W-1:0] IDX_STAT    = 4'd9;

  typedef struct packed {
    logic       after;
    logic [1:0] size;
    logic [1:0] dir;
    logic [1:0] kind;
    logic [1:0] bus;
  } cond_t;

  localparam int unsigned COND_W = $bits(cond_t);

  function automatic logic cond_unprog(cond_t c);
    return (c.bus == 2'b00) || (c.kind == 2'b00) || (c.dir == 2'b00);
  endfunction
endpackage

// File: rtl/bkpt_regs.sv
module bkpt_regs
  import bkpt_pkg::*;
#(
  parameter int unsigned RW = 32,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [REG_IDX_W-1:0] idx,
  input  logic [RW-1:0]        wdata,
  output logic [AW-1:0]        ref_addr [2],
  output logic [AW-1:0]        addr_mask [2],
  output cond_t                cond [2],
  output logic [DW-1:0]        ref_data,
  output logic [DW-1:0]        data_mask,
  output logic                 seq_mode,
  output logic                 ctrl_wr,
  output logic                 stat_wr,
  output logic [1:0]           stat_keep
);
  assign ctrl_wr   = we && (idx == IDX_CTRL);
  assign stat_wr   = we && (idx == IDX_STAT);
  assign stat_keep = wdata[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_addr[0]  <= '0;
      ref_addr[1]  <= '0;
      addr_mask[0] <= '0;
      addr_mask[1] <= '0;
      cond[0]      <= '0;
      cond[1]      <= '0;
      ref_data     <= '0;
      data_mask    <= '0;
      seq_mode     <= 1'b0;
    end else if (we) begin
      case (idx)
        IDX_A_ADDR:  ref_addr[0]  <= wdata[AW-1:0];
        IDX_A_MASK:  addr_mask[0] <= wdata[AW-1:0];
        IDX_A_COND:  cond[0]      <= cond_t'(wdata[COND_W-1:0]);
        IDX_B_ADDR:  ref_addr[1]  <= wdata[AW-1:0];
        IDX_B_MASK:  addr_mask[1] <= wdata[AW-1:0];
        IDX_B_COND:  cond[1]      <= cond_t'(wdata[COND_W-1:0]);
        IDX_B_DATA:  ref_data     <= wdata[DW-1:0];
        IDX_B_DMASK: data_mask    <= wdata[DW-1:0];
        IDX_CTRL:    seq_mode     <= wdata[0];
        default: ;
      endcase
    end
  end

  assert_ctrl_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (seq_mode == $past(wdata[0])));
endmodule

// File: rtl/bkpt_chan.sv
module bkpt_chan
  import bkpt_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter bit          HAS_DATA = 1'b0
) (
  input  cond_t         cond,
  input  logic [AW-1:0] ref_addr,
  input  logic [AW-1:0] addr_mask,
  input  logic [DW-1:0] ref_data,
  input  logic [DW-1:0] data_mask,
  input  logic          bus_valid,
  input  logic          bus_sel,
  input  logic          bus_ifetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  output logic          hit,
  output logic          post
);
  logic addr_ok, bus_ok, kind_ok, dir_ok, size_ok, data_ok;

  assign addr_ok = ((bus_addr ^ ref_addr) & ~addr_mask) == '0;
  assign bus_ok  = cond.bus[bus_sel];
  assign kind_ok = cond.kind[bus_ifetch ? 1'b0 : 1'b1];
  assign dir_ok  = cond.dir[bus_write];
  assign size_ok = (cond.size == 2'd0) || (cond.size == bus_size);

  generate
    if (HAS_DATA) begin : g_data
      assign data_ok = ((bus_data ^ ref_data) & ~data_mask) == '0;
    end else begin : g_nodata
      logic unused_data;
      assign unused_data = ^{bus_data, ref_data, data_mask};
      assign data_ok     = 1'b1;
    end
  endgenerate

  assign hit  = bus_valid && addr_ok && bus_ok && kind_ok && dir_ok && size_ok && data_ok;
  assign post = cond.after && bus_ifetch;
endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seq_mode,
  input  logic       ctrl_wr,
  input  logic       stat_wr,
  input  logic [1:0] stat_keep,
  input  logic       hit_a,
  input  logic       post_a,
  input  logic       hit_b,
  input  logic       post_b,
  input  logic       insn_done,
  output logic       brk_req,
  output logic       flag_a,
  output logic       flag_b
);
  logic armed, pend;
  logic fire_a, fire_b, pre_now, post_set;

  assign fire_a   = hit_a && !seq_mode;
  assign fire_b   = hit_b && (!seq_mode || armed);
  assign pre_now  = (fire_a && !post_a) || (fire_b && !post_b);
  assign post_set = (fire_a && post_a) || (fire_b && post_b);
  assign brk_req  = pre_now || (pend && insn_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      pend   <= 1'b0;
      flag_a <= 1'b0;
      flag_b <= 1'b0;
    end else begin
      pend <= post_set || (pend && !insn_done);
      if (ctrl_wr || !seq_mode || fire_b) armed <= 1'b0;
      else if (hit_a)                     armed <= 1'b1;
      flag_a <= hit_a || (flag_a && !(stat_wr && !stat_keep[0]));
      flag_b <= hit_b || (flag_b && !(stat_wr && !stat_keep[1]));
    end
  end

  assert_brk_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (hit_a || hit_b || insn_done));
  assert_unarmed_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && !armed && !pend) |-> !brk_req);
  assert_disarm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && hit_b && armed) |=> !armed);
  assert_pre_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_mode && hit_a && !post_a) |-> brk_req);
  assert_post_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && insn_done) |-> brk_req);
  assert_pend_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && insn_done && !post_set) |=> !pend);
  assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a |=> flag_a) and (hit_b |=> flag_b));
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int unsigned RW = 32,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [REG_IDX_W-1:0] cfg_addr,
  input  logic [RW-1:0]        cfg_wdata,
  input  logic                 bus_valid,
  input  logic                 bus_sel,
  input  logic                 bus_ifetch,
  input  logic                 bus_write,
  input  logic [1:0]           bus_size,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_data,
  input  logic                 insn_done,
  output logic                 brk_req,
  output logic                 hit_flag_a,
  output logic                 hit_flag_b
);
  localparam int unsigned NCH = 2;

  logic [AW-1:0] ref_addr  [NCH];
  logic [AW-1:0] addr_mask [NCH];
  cond_t         cond      [NCH];
  logic [DW-1:0] ref_data, data_mask;
  logic          seq_mode, ctrl_wr, stat_wr;
  logic [1:0]    stat_keep;
  logic [NCH-1:0] hit, post;

  bkpt_regs #(.RW(RW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_addr), .wdata(cfg_wdata),
    .ref_addr(ref_addr), .addr_mask(addr_mask), .cond(cond),
    .ref_data(ref_data), .data_mask(data_mask), .seq_mode(seq_mode),
    .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .stat_keep(stat_keep)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      bkpt_chan #(.AW(AW), .DW(DW), .HAS_DATA(i == 1)) u_chan (
        .cond(cond[i]), .ref_addr(ref_addr[i]), .addr_mask(addr_mask[i]),
        .ref_data(ref_data), .data_mask(data_mask),
        .bus_valid(bus_valid), .bus_sel(bus_sel), .bus_ifetch(bus_ifetch),
        .bus_write(bus_write), .bus_size(bus_size), .bus_addr(bus_addr),
        .bus_data(bus_data), .hit(hit[i]), .post(post[i])
      );

      assert_unprog_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cond_unprog(cond[i]) |-> !hit[i]);
    end
  endgenerate

  bkpt_seq u_seq (
    .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode), .ctrl_wr(ctrl_wr),
    .stat_wr(stat_wr), .stat_keep(stat_keep),
    .hit_a(hit[0]), .post_a(post[0]), .hit_b(hit[1]), .post_b(post[1]),
    .insn_done(insn_done), .brk_req(brk_req),
    .flag_a(hit_flag_a), .flag_b(hit_flag_b)
  );
endmodule

// File: tb/tb_bkpt_unit.sv
module tb_bkpt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        bus_valid = 1'b0, bus_sel = 1'b0, bus_ifetch = 1'b0, bus_write = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic        insn_done = 1'b0;
  logic        brk_req, hit_flag_a, hit_flag_b;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_addr [2], m_mask [2];
  logic [8:0]  m_cond [2];
  logic [31:0] m_data, m_dmask;
  logic        m_seq, m_armed, m_pend, m_fa, m_fb;

  always #5 clk = ~clk;

  bkpt_unit dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_valid(bus_valid), .bus_sel(bus_sel),
    .bus_ifetch(bus_ifetch), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_data(bus_data), .insn_done(insn_done),
    .brk_req(brk_req), .hit_flag_a(hit_flag_a), .hit_flag_b(hit_flag_b)
  );

  function automatic logic [8:0] mk(logic [1:0] b, logic [1:0] k, logic [1:0] d,
                                    logic [1:0] s, logic aft);
    return {aft, s, d, k, b};
  endfunction

  function automatic logic f_match(int ch, logic sel, logic ifc, logic wr,
                                   logic [1:0] sz, logic [31:0] a, logic [31:0] d);
    logic [8:0] c;
    logic ok;
    c  = m_cond[ch];
    ok = (((a ^ m_addr[ch]) & ~m_mask[ch]) == 0);
    ok = ok && c[sel ? 1 : 0];
    ok = ok && c[ifc ? 2 : 3];
    ok = ok && c[wr ? 5 : 4];
    ok = ok && ((c[7:6] == 2'd0) || (c[7:6] == sz));
    if (ch == 1) ok = ok && (((d ^ m_data) & ~m_dmask) == 0);
    return ok;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [31:0] val);
    cfg_we = 1'b1; cfg_addr = idx; cfg_wdata = val;
    bus_valid = 1'b0; insn_done = 1'b0;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    case (idx)
      4'd0: m_addr[0] = val;
      4'd1: m_mask[0] = val;
      4'd2: m_cond[0] = val[8:0];
      4'd3: m_addr[1] = val;
      4'd4: m_mask[1] = val;
      4'd5: m_cond[1] = val[8:0];
      4'd6: m_data = val;
      4'd7: m_dmask = val;
      4'd8: begin m_seq = val[0]; m_armed = 1'b0; end
      4'd9: begin m_fa = m_fa & val[0]; m_fb = m_fb & val[1]; end
      default: ;
    endcase
  endtask

  task automatic cyc(string tag, logic v, logic sel, logic ifc, logic w,
                     logic [1:0] sz, logic [31:0] a, logic [31:0] d, logic done);
    logic ha, hb, pa, pb, fa, fb, exp;
    bus_valid = v; bus_sel = sel; bus_ifetch = ifc; bus_write = w;
    bus_size = sz; bus_addr = a; bus_data = d; insn_done = done;
    #4;
    ha = v && f_match(0, sel, ifc, w, sz, a, d);
    hb = v && f_match(1, sel, ifc, w, sz, a, d);
    pa = m_cond[0][8] && ifc;
    pb = m_cond[1][8] && ifc;
    fa = ha && !m_seq;
    fb = hb && (!m_seq || m_armed);
    exp = (fa && !pa) || (fb && !pb) || (m_pend && done);
    check(tag, brk_req, exp);
    @(posedge clk); #1;
    m_pend = (fa && pa) || (fb && pb) || (m_pend && !done);
    if (!m_seq || fb) m_armed = 1'b0;
    else if (ha) m_armed = 1'b1;
    m_fa = m_fa || ha;
    m_fb = m_fb || hb;
    bus_valid = 1'b0; insn_done = 1'b0;
    check({tag, " flagA"}, hit_flag_a, m_fa);
    check({tag, " flagB"}, hit_flag_b, m_fb);
  endtask

  task automatic fetch(string tag, logic [31:0] a);
    cyc(tag, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, a, 32'h0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2; i++) begin
      m_addr[i] = '0; m_mask[i] = '0; m_cond[i] = '0;
    end
    m_data = '0; m_dmask = '0; m_seq = 0; m_armed = 0; m_pend = 0; m_fa = 0; m_fb = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R12 reset brk", brk_req, 1'b0);
    check("R12 reset flagA", hit_flag_a, 1'b0);
    check("R12 reset flagB", hit_flag_b, 1'b0);
    fetch("R12 unconfigured", 32'h0);

    // R1 masked window on channel A, local bus fetch read, size ignored
    wr(4'd0, 32'h0000_8010); wr(4'd1, 32'h0000_0006);
    wr(4'd2, {23'd0, mk(2'b01, 2'b01, 2'b01, 2'd0, 1'b0)});
    fetch("R1 8010", 32'h8010); fetch("R1 8012", 32'h8012);
    fetch("R1 8014", 32'h8014); fetch("R1 8016", 32'h8016);
    fetch("R1 8011", 32'h8011); fetch("R1 8018", 32'h8018);
    // R2 single qualifier mismatches
    cyc("R2 peripheral bus", 1, 1, 1, 0, 2'd2, 32'h8010, 0, 0);
    cyc("R2 data kind", 1, 0, 0, 0, 2'd2, 32'h8010, 0, 0);
    cyc("R2 write dir", 1, 0, 1, 1, 2'd2, 32'h8010, 0, 0);
    // R3 size qualifier
    wr(4'd2, {23'd0, mk(2'b11, 2'b11, 2'b11, 2'd2, 1'b0)});
    cyc("R3 word", 1, 1, 0, 1, 2'd2, 32'h8012, 0, 0);
    cyc("R3 byte", 1, 1, 0, 1, 2'd1, 32'h8012, 0, 0);
    cyc("R3 long", 1, 0, 1, 0, 2'd3, 32'h8012, 0, 0);
    // R11 status clear: clear A keep B, then clear both
    wr(4'd9, 32'h2);
    check("R11 flagA cleared", hit_flag_a, 1'b0);
    cyc("R11 idle", 0, 0, 0, 0, 2'd0, 0, 0, 0);
    // R4 unprogrammed fields on B
    wr(4'd3, 32'h100); wr(4'd4, 32'hFFFF_FFFF); wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd5, {23'd0, mk(2'b11, 2'b00, 2'b11, 2'd0, 1'b0)});
    cyc("R4 kind zero", 1, 0, 0, 0, 2'd2, 32'h100, 0, 0);
    wr(4'd5, {23'd0, mk(2'b00, 2'b11, 2'b11, 2'd0, 1'b0)});
    cyc("R4 bus zero", 1, 0, 0, 0, 2'd2, 32'h100, 0, 0);
    // R5 data compare on B
    wr(4'd2, 32'h0); wr(4'd4, 32'h0);
    wr(4'd5, {23'd0, mk(2'b01, 2'b10, 2'b10, 2'd0, 1'b0)});
    wr(4'd6, 32'hCAFE_0000); wr(4'd7, 32'h0000_00FF);
    cyc("R5 data equal", 1, 0, 0, 1, 2'd3, 32'h100, 32'hCAFE_0000, 0);
    cyc("R5 masked diff", 1, 0, 0, 1, 2'd3, 32'h100, 32'hCAFE_00A5, 0);
    cyc("R5 unmasked diff", 1, 0, 0, 1, 2'd3, 32'h100, 32'hCAFF_0000, 0);
    wr(4'd9, 32'h0);
    check("R11 flagB cleared", hit_flag_b, 1'b0);
    // R7 sequence: B alone, then A, then B; R8 disarm
    wr(4'd2, {23'd0, mk(2'b01, 2'b10, 2'b01, 2'd0, 1'b0)});
    wr(4'd0, 32'h200); wr(4'd1, 32'h0);
    wr(4'd8, 32'h1);
    cyc("R7 B unarmed", 1, 0, 0, 1, 2'd1, 32'h100, 32'hCAFE_0000, 0);
    cyc("R7 A arms", 1, 0, 0, 0, 2'd1, 32'h200, 0, 0);
    cyc("R7 B armed", 1, 0, 0, 1, 2'd1, 32'h100, 32'hCAFE_0000, 0);
    cyc("R7 B after disarm", 1, 0, 0, 1, 2'd1, 32'h100, 32'hCAFE_0000, 0);
    cyc("R8 A arms", 1, 0, 0, 0, 2'd1, 32'h200, 0, 0);
    wr(4'd8, 32'h1);
    cyc("R8 B after ctrl write", 1, 0, 0, 1, 2'd1, 32'h100, 32'hCAFE_0000, 0);
    // R9/R10 timing, independent mode
    wr(4'd8, 32'h0);
    wr(4'd2, {23'd0, mk(2'b01, 2'b01, 2'b01, 2'd0, 1'b1)});
    fetch("R10 post fetch", 32'h200);
    cyc("R10 wait", 0, 0, 0, 0, 2'd0, 0, 0, 0);
    cyc("R10 done", 0, 0, 0, 0, 2'd0, 0, 0, 1);
    cyc("R10 second done", 0, 0, 0, 0, 2'd0, 0, 0, 1);
    wr(4'd2, {23'd0, mk(2'b01, 2'b11, 2'b01, 2'd0, 1'b1)});
    cyc("R9 data immediate", 1, 0, 0, 0, 2'd2, 32'h200, 0, 0);
    wr(4'd2, {23'd0, mk(2'b01, 2'b01, 2'b01, 2'd0, 1'b0)});
    fetch("R9 pre fetch", 32'h200);
    // R6 random mix of both modes
    for (int ep = 0; ep < 24; ep++) begin
      wr(4'd0, $urandom & 32'hFFFF_FFC0); wr(4'd1, $urandom & 32'h1E);
      wr(4'd2, {23'd0, 9'($urandom)});
      wr(4'd3, $urandom & 32'hFFFF_FFC0); wr(4'd4, $urandom & 32'h1E);
      wr(4'd5, {23'd0, 9'($urandom)});
      wr(4'd6, $urandom); wr(4'd7, $urandom & 32'hFFFF_0000);
      wr(4'd8, {31'd0, 1'($urandom)});
      for (int n = 0; n < 120; n++) begin
        logic [31:0] a, d;
        a = ((($urandom % 2) == 0) ? m_addr[0] : m_addr[1]) ^ ($urandom & 32'h1F);
        d = (($urandom % 3) == 0) ? $urandom : (m_data ^ ($urandom & 32'hFFFF));
        if (($urandom % 40) == 0) wr(4'd9, {30'd0, 2'($urandom)});
        cyc("R6 random", ($urandom % 4) != 0, 1'($urandom), 1'($urandom),
            1'($urandom), 2'($urandom), a, d, ($urandom % 4) == 0);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule